// File: doc/BRIEF.md
# Head Stepper for Seek and Recalibrate

This block positions the read/write head of up to four disk drives. A start strobe carries a request kind (seek or recalibrate), a drive number, a head number and, for a seek, a target cylinder. The block keeps a present-cylinder register for every drive. It drives a direction line and a train of step pulses at a programmable rate until the head arrives. For a recalibrate it instead steps outward until a track-zero input is seen, or until it gives up.

When a move ends, the block records a status byte and raises an interrupt line. The status byte carries a seek-end flag, the drive, the head and a completion code. A sense query then returns that status byte and the present cylinder of the drive that finished, and the query clears the interrupt. A per-drive busy vector shows which drive is moving.

Two configuration bytes set the timing. The first holds the step rate in its upper nibble and the head-unload time in its lower nibble. The second holds the head-load time in bits 7..1 and a transfer-mode flag in bit 0. All timing counts a tick that is derived from the clock by a parameterised divider. After each move, a head-settle output stays high for the head-load time. A head-unload output then rises once the unload time has passed with no further move.

Top module: `head_stepper`

## Requirements
- R1: After reset, seekBusy is 0, stepOut is 0, irq is 0, every present cylinder is 0, headSettle is 0, headUnload is 1, nonDmaMode is 0, and senseSt0 reads 0x80.
- R2: A seek sets dirOut to 1 when the target is above the present cylinder and to 0 otherwise. It changes the present cylinder by one in that direction on each step pulse, and it ends on the pulse that makes the two equal.
- R3: A tick occurs once every TICK_DIV clocks. Each step pulse is high for exactly one tick. The first pulse rises on the first tick after the start. Successive rises are P ticks apart, where P = max(2, 16 - v), v is bits 7..4 of specRateUnload, and v = 0 gives 16.
- R4: While a drive moves, bit n of seekBusy (n = drive number) is high, no other bit is high, and driveSel shows the drive. The bit falls on the clock edge where the move ends.
- R5: On completion, irq rises and the status byte has bit 5 = 1, bit 2 = head, bits 1..0 = drive and bits 7..6 = 00 for a normal end. Busy falling and irq rising happen on the same edge.
- R6: A seek whose target equals the present cylinder completes on the edge that accepts the start. It issues no step pulse and never raises a busy bit.
- R7: A recalibrate drives dirOut to 0 and steps outward. It ends normally when trackZero is 1 at the start, or when trackZero is 1 on the tick that ends a pulse. The present cylinder then becomes 0.
- R8: If trackZero is still 0 when the 77th recalibrate pulse ends, the move ends abnormally. The status byte then has bits 7..6 = 01, bit 4 = 1 and bit 5 = 1. The cylinder counts down by one per pulse and stops at 0.
- R9: While irq is high, senseSt0 and senseCyl show the stored status and the present cylinder of the drive that finished. A senseReq while irq is high clears irq at the next edge, unless a completion lands on that same edge. With irq low, the outputs read 0x80 and 0.
- R10: A start strobe that arrives while a move is in progress is ignored. It affects neither the moving drive nor the drive it names.
- R11: nonDmaMode follows bit 0 of specLoadMode. After each completion, headSettle stays high for 2*h ticks, where h = specLoadMode bits 7..1.
- R12: Once headSettle is low, headUnload rises after 16*u ticks with no new start, where u = specRateUnload bits 3..0 and u = 0 gives 16. headUnload falls on the edge that accepts a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | One-cycle request strobe |
| startRecal | input | 1 | 1 = recalibrate, 0 = seek |
| startDrive | input | 2 | Drive number of the request |
| startHead | input | 1 | Head number reported in the status |
| startCyl | input | CYL_W | Seek target cylinder |
| specValid | input | 1 | Loads the two configuration bytes |
| specRateUnload | input | 8 | Step-rate nibble (7..4), unload nibble (3..0) |
| specLoadMode | input | 8 | Head-load time (7..1), transfer-mode flag (0) |
| senseReq | input | 1 | Sense query strobe, acknowledges the interrupt |
| trackZero | input | 1 | Head is at the outermost cylinder |
| stepOut | output | 1 | Step pulse |
| dirOut | output | 1 | 1 = toward higher cylinders |
| driveSel | output | 2 | Drive being moved (last one used) |
| seekBusy | output | NUM_DRIVES | Per-drive moving flags |
| irq | output | 1 | Completion interrupt |
| senseSt0 | output | 8 | Status byte of the last completion |
| senseCyl | output | CYL_W | Present cylinder of the interrupting drive |
| headSettle | output | 1 | Head-load delay running |
| headUnload | output | 1 | Head unload due |
| nonDmaMode | output | 1 | Transfer-mode flag from configuration |

## Verification
The assertions take for granted that startDrive names an existing drive, and that the configuration bytes are loaded only while no drive is moving, so the step period cannot change in the middle of a pulse train. They also assume that trackZero is steady around the tick edges where a pulse ends. The stimulus keeps to these rules. It issues configuration only between moves and uses drive numbers 0 to 3. It changes trackZero only at falling clock edges, in response to the pulses counted so far.

// File: rtl/hs_pkg.sv
package hs_pkg;
  // Control to datapath strobes
  typedef struct packed {
    logic       inc;
    logic       dec;
    logic       zero;
    logic [1:0] drv;
    logic       start;
    logic       done;
  } hsStrobe_t;

  typedef enum logic { ST_IDLE = 1'b0, ST_MOVE = 1'b1 } hsState_t;

  // Step period in ticks from the rate nibble; pulse and gap each need a tick
  function automatic logic [4:0] stepPeriod(input logic [3:0] v);
    logic [4:0] p;
    p = (v == 4'd0) ? 5'd16 : 5'd16 - {1'b0, v};
    return (p < 5'd2) ? 5'd2 : p;
  endfunction
endpackage

// File: rtl/hs_tick.sv
module hs_tick #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int CntW = $clog2(TICK_DIV + 1);
  logic [CntW-1:0] divCnt;

  assign tick = (divCnt == CntW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + CntW'(1);
  end
endmodule

// File: rtl/hs_datapath.sv
module hs_datapath import hs_pkg::*; #(
  parameter int NUM_DRIVES = 4,
  parameter int CYL_W      = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              tick,
  input  hsStrobe_t                         stb,
  input  logic                              specValid,
  input  logic [7:0]                        specRateUnload,
  input  logic [7:0]                        specLoadMode,
  output logic [NUM_DRIVES-1:0][CYL_W-1:0]  cylAll,
  output logic [4:0]                        period,
  output logic                              headSettle,
  output logic                              headUnload,
  output logic                              nonDmaMode
);
  logic [3:0] rateNib, unloadNib;
  logic [6:0] loadVal;
  logic [7:0] settleCnt;
  logic [8:0] unloadCnt;
  logic [CYL_W-1:0] cylReg [NUM_DRIVES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateNib <= '0; unloadNib <= '0; loadVal <= '0; nonDmaMode <= 1'b0;
    end else if (specValid) begin
      rateNib    <= specRateUnload[7:4];
      unloadNib  <= specRateUnload[3:0];
      loadVal    <= specLoadMode[7:1];
      nonDmaMode <= specLoadMode[0];
    end
  end

  assign period = stepPeriod(rateNib);

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_cyl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cylReg[d] <= '0;
      else if (stb.drv == 2'(d)) begin
        if (stb.zero)     cylReg[d] <= '0;
        else if (stb.inc) cylReg[d] <= cylReg[d] + CYL_W'(1);
        else if (stb.dec) cylReg[d] <= cylReg[d] - CYL_W'(1);
      end
    end
    assign cylAll[d] = cylReg[d];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt  <= '0;
      unloadCnt  <= '0;
      headUnload <= 1'b1;
    end else begin
      if (stb.done) begin
        settleCnt <= {loadVal, 1'b0};
        unloadCnt <= {(unloadNib == 4'd0), unloadNib, 4'b0000};
      end else if (stb.start) begin
        settleCnt <= '0;
        unloadCnt <= '0;
      end else if (tick) begin
        if (settleCnt != 8'd0)      settleCnt <= settleCnt - 8'd1;
        else if (unloadCnt != 9'd0) unloadCnt <= unloadCnt - 9'd1;
      end
      if (stb.start) headUnload <= 1'b0;
      else if (tick && settleCnt == 8'd0 && unloadCnt == 9'd1) headUnload <= 1'b1;
    end
  end

  assign headSettle = (settleCnt != 8'd0);

  // R12
  settle_unload_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    headSettle |-> !headUnload);
  // R11
  settle_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.done && loadVal != 7'd0) |=> headSettle);
endmodule

// File: rtl/hs_control.sv
module hs_control import hs_pkg::*; #(
  parameter int NUM_DRIVES  = 4,
  parameter int CYL_W       = 8,
  parameter int RECAL_LIMIT = 77
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              tick,
  input  logic                              startValid,
  input  logic                              startRecal,
  input  logic [1:0]                        startDrive,
  input  logic                              startHead,
  input  logic [CYL_W-1:0]                  startCyl,
  input  logic                              senseReq,
  input  logic                              trackZero,
  input  logic [4:0]                        period,
  input  logic [NUM_DRIVES-1:0][CYL_W-1:0]  cylAll,
  output hsStrobe_t                         stb,
  output logic                              stepOut,
  output logic                              dirOut,
  output logic [1:0]                        driveSel,
  output logic [NUM_DRIVES-1:0]             seekBusy,
  output logic                              irq,
  output logic [7:0]                        senseSt0,
  output logic [CYL_W-1:0]                  senseCyl
);
  localparam int CntW = $clog2(RECAL_LIMIT + 1);

  hsState_t        state;
  logic [1:0]      drv, irqDrv;
  logic            head, isRecal;
  logic [CYL_W-1:0] target, curCyl, startCur, nextCyl;
  logic [3:0]      gap;
  logic [CntW-1:0] steps;
  logic [7:0]      st0, doneSt0;
  logic            startOk, immDone, fall, reached, giveUp, moveEnd;

  always_comb begin
    startOk  = startValid && (state == ST_IDLE);
    startCur = cylAll[startDrive];
    curCyl   = cylAll[drv];
    immDone  = startOk && (startRecal ? trackZero : (startCyl == startCur));
    fall     = (state == ST_MOVE) && tick && stepOut;
    nextCyl  = dirOut ? curCyl + CYL_W'(1) : ((curCyl == '0) ? '0 : curCyl - CYL_W'(1));
    reached  = isRecal ? trackZero : (nextCyl == target);
    giveUp   = isRecal && !trackZero && (steps == CntW'(RECAL_LIMIT - 1));
    moveEnd  = fall && (reached || giveUp);
    stb.inc   = fall && dirOut;
    stb.dec   = fall && !dirOut && (curCyl != '0);
    stb.zero  = (immDone && startRecal) || (fall && isRecal && trackZero);
    stb.drv   = startOk ? startDrive : drv;
    stb.start = startOk;
    stb.done  = immDone || moveEnd;
    doneSt0   = startOk ? {3'b001, 2'b00, startHead, startDrive}
                        : {1'b0, giveUp, 1'b1, giveUp, 1'b0, head, drv};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; drv <= '0; head <= 1'b0; isRecal <= 1'b0; target <= '0;
      dirOut <= 1'b0; stepOut <= 1'b0; gap <= '0; steps <= '0;
    end else if (startOk) begin
      drv <= startDrive; head <= startHead; target <= startCyl; isRecal <= startRecal;
      dirOut  <= !startRecal && (startCyl > startCur);
      stepOut <= 1'b0; gap <= '0; steps <= '0;
      state   <= immDone ? ST_IDLE : ST_MOVE;
    end else if (state == ST_MOVE && tick) begin
      if (!stepOut) begin
        if (gap == 4'd0) stepOut <= 1'b1;
        else             gap <= gap - 4'd1;
      end else begin
        stepOut <= 1'b0;
        steps   <= steps + CntW'(1);
        gap     <= 4'(period - 5'd2);
        if (moveEnd) state <= ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq <= 1'b0; st0 <= '0; irqDrv <= '0;
    end else if (stb.done) begin
      irq <= 1'b1; st0 <= doneSt0; irqDrv <= stb.drv;
    end else if (senseReq && irq) begin
      irq <= 1'b0;
    end
  end

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_busy
    assign seekBusy[d] = (state == ST_MOVE) && (drv == 2'(d));
  end

  assign driveSel = drv;
  assign senseSt0 = irq ? st0 : 8'h80;
  assign senseCyl = irq ? cylAll[irqDrv] : '0;

  // R3
  pulse_one_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepOut && tick) |=> !stepOut);
  // R4
  step_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepOut |-> (seekBusy != '0));
  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((seekBusy != '0) && !stb.done) |=> $stable(dirOut));
  // R5
  irq_seek_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> senseSt0[5]);
  // R5
  busy_fall_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((seekBusy == '0) && ($past(seekBusy) != '0)) |-> irq);
endmodule

// File: rtl/head_stepper.sv
module head_stepper import hs_pkg::*; #(
  parameter int NUM_DRIVES  = 4,
  parameter int CYL_W       = 8,
  parameter int TICK_DIV    = 1000,
  parameter int RECAL_LIMIT = 77
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startValid,
  input  logic                  startRecal,
  input  logic [1:0]            startDrive,
  input  logic                  startHead,
  input  logic [CYL_W-1:0]      startCyl,
  input  logic                  specValid,
  input  logic [7:0]            specRateUnload,
  input  logic [7:0]            specLoadMode,
  input  logic                  senseReq,
  input  logic                  trackZero,
  output logic                  stepOut,
  output logic                  dirOut,
  output logic [1:0]            driveSel,
  output logic [NUM_DRIVES-1:0] seekBusy,
  output logic                  irq,
  output logic [7:0]            senseSt0,
  output logic [CYL_W-1:0]      senseCyl,
  output logic                  headSettle,
  output logic                  headUnload,
  output logic                  nonDmaMode
);
  logic                             tick;
  hsStrobe_t                        stb;
  logic [4:0]                       period;
  logic [NUM_DRIVES-1:0][CYL_W-1:0] cylAll;

  hs_tick #(.TICK_DIV(TICK_DIV)) i_tick (.clk(clk), .rstN(rstN), .tick(tick));

  hs_control #(.NUM_DRIVES(NUM_DRIVES), .CYL_W(CYL_W), .RECAL_LIMIT(RECAL_LIMIT)) i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .startValid(startValid), .startRecal(startRecal),
    .startDrive(startDrive), .startHead(startHead), .startCyl(startCyl), .senseReq(senseReq),
    .trackZero(trackZero), .period(period), .cylAll(cylAll), .stb(stb), .stepOut(stepOut),
    .dirOut(dirOut), .driveSel(driveSel), .seekBusy(seekBusy), .irq(irq),
    .senseSt0(senseSt0), .senseCyl(senseCyl));

  hs_datapath #(.NUM_DRIVES(NUM_DRIVES), .CYL_W(CYL_W)) i_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .stb(stb), .specValid(specValid),
    .specRateUnload(specRateUnload), .specLoadMode(specLoadMode), .cylAll(cylAll),
    .period(period), .headSettle(headSettle), .headUnload(headUnload), .nonDmaMode(nonDmaMode));
endmodule

// File: tb/test_head_stepper.sv
`timescale 1ns/1ps
module test_head_stepper;
  localparam int TDIV = 4;
  localparam int RLIM = 77;

  logic clk = 1'b0, rstN = 1'b0;
  logic startValid = 0, startRecal = 0, startHead = 0, specValid = 0, senseReq = 0, trackZero = 0;
  logic [1:0] startDrive = 0;
  logic [7:0] startCyl = 0, specRateUnload = 0, specLoadMode = 0;
  logic stepOut, dirOut, irq, headSettle, headUnload, nonDmaMode;
  logic [1:0] driveSel;
  logic [3:0] seekBusy;
  logic [7:0] senseSt0, senseCyl;

  int tests = 0, fails = 0, cyc = 0;
  int pulses = 0, lastRise = 0, riseGap = 0, tzAfter = -1;
  bit prevStep = 0, finished = 0;

  always #2.5 clk = ~clk;

  head_stepper #(.TICK_DIV(TDIV), .RECAL_LIMIT(RLIM)) i_head_stepper (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startRecal(startRecal),
    .startDrive(startDrive), .startHead(startHead), .startCyl(startCyl),
    .specValid(specValid), .specRateUnload(specRateUnload), .specLoadMode(specLoadMode),
    .senseReq(senseReq), .trackZero(trackZero), .stepOut(stepOut), .dirOut(dirOut),
    .driveSel(driveSel), .seekBusy(seekBusy), .irq(irq), .senseSt0(senseSt0),
    .senseCyl(senseCyl), .headSettle(headSettle), .headUnload(headUnload),
    .nonDmaMode(nonDmaMode));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // Behavioural reference model
  int mT, mDrv, mTgt, mGap, mSteps, mSt0, mIrqDrv, mSettle, mUnl, mSrt, mHut, mHlt;
  bit mMov, mStep, mDir, mIrq, mRec, mHead, mUnload, mNd;
  int cyl[4];

  always @(posedge clk) begin : model
    bit tk, doneNow, startNow, irqOld;
    int per, settleOld;
    cyc++;
    if (!rstN) begin
      mT = 0; mDrv = 0; mTgt = 0; mGap = 0; mSteps = 0; mSt0 = 0; mIrqDrv = 0;
      mSettle = 0; mUnl = 0; mSrt = 0; mHut = 0; mHlt = 0;
      mMov = 0; mStep = 0; mDir = 0; mIrq = 0; mRec = 0; mHead = 0; mUnload = 1; mNd = 0;
      for (int i = 0; i < 4; i++) cyl[i] = 0;
    end else begin
      tk = (mT == TDIV - 1);
      mT = tk ? 0 : mT + 1;
      per = (mSrt == 0) ? 16 : 16 - mSrt;
      if (per < 2) per = 2;
      doneNow = 0; startNow = 0; irqOld = mIrq; settleOld = mSettle;
      if (startValid && !mMov) begin
        startNow = 1; mDrv = startDrive; mHead = startHead; mTgt = startCyl; mRec = startRecal;
        mSteps = 0; mStep = 0; mGap = 0;
        mDir = !startRecal && (startCyl > cyl[startDrive]);
        if (startRecal ? trackZero : (int'(startCyl) == cyl[startDrive])) begin
          doneNow = 1;
          if (startRecal) cyl[mDrv] = 0;
          mSt0 = 'h20 | (int'(mHead) << 2) | mDrv;
        end else mMov = 1;
      end else if (mMov && tk) begin
        if (!mStep) begin
          if (mGap == 0) mStep = 1; else mGap--;
        end else begin
          mStep = 0; mSteps++; mGap = per - 2;
          if (mDir) cyl[mDrv]++; else if (cyl[mDrv] > 0) cyl[mDrv]--;
          if ((mRec && trackZero) || (!mRec && cyl[mDrv] == mTgt)) begin
            if (mRec) cyl[mDrv] = 0;
            doneNow = 1; mMov = 0; mSt0 = 'h20 | (int'(mHead) << 2) | mDrv;
          end else if (mRec && mSteps == RLIM) begin
            doneNow = 1; mMov = 0; mSt0 = 'h70 | (int'(mHead) << 2) | mDrv;
          end
        end
      end
      if (doneNow) begin mIrq = 1; mIrqDrv = mDrv; end
      else if (senseReq && irqOld) mIrq = 0;
      if (doneNow) begin
        mSettle = 2 * mHlt; mUnl = 16 * ((mHut == 0) ? 16 : mHut);
      end else if (startNow) begin
        mSettle = 0; mUnl = 0;
      end else if (tk) begin
        if (settleOld != 0) mSettle--;
        else if (mUnl != 0) begin
          if (mUnl == 1) mUnload = 1;
          mUnl--;
        end
      end
      if (startNow) mUnload = 0;
      if (specValid) begin
        mSrt = specRateUnload[7:4]; mHut = specRateUnload[3:0];
        mHlt = specLoadMode[7:1]; mNd = specLoadMode[0];
      end
    end
  end

  // Cycle-by-cycle comparison and pulse monitor
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R3 stepOut", stepOut, mStep);
      chk("R2 dirOut", dirOut, mDir);
      chk("R4 seekBusy", seekBusy, mMov ? (1 << mDrv) : 0);
      chk("R4 driveSel", driveSel, mDrv);
      chk("R5 irq", irq, mIrq);
      chk("R9 senseSt0", senseSt0, mIrq ? mSt0 : 'h80);
      chk("R9 senseCyl", senseCyl, mIrq ? cyl[mIrqDrv] : 0);
      chk("R11 headSettle", headSettle, mSettle != 0);
      chk("R12 headUnload", headUnload, mUnload);
      chk("R11 nonDmaMode", nonDmaMode, mNd);
      if (stepOut && !prevStep) begin
        pulses++; riseGap = cyc - lastRise; lastRise = cyc;
      end
      prevStep = stepOut;
      trackZero <= (tzAfter >= 0) && (pulses >= tzAfter);
    end
  end

  task automatic doSpec(input logic [7:0] b0, input logic [7:0] b1);
    @(negedge clk); specValid = 1; specRateUnload = b0; specLoadMode = b1;
    @(negedge clk); specValid = 0;
  endtask

  task automatic doStart(input bit rec, input int d, input bit h, input int c);
    @(negedge clk); startValid = 1; startRecal = rec; startDrive = 2'(d); startHead = h; startCyl = 8'(c);
    @(negedge clk); startValid = 0;
  endtask

  task automatic waitIrq();
    for (int i = 0; i < 5000 && !irq; i++) @(negedge clk);
  endtask

  task automatic doSense();
    @(negedge clk); senseReq = 1;
    @(negedge clk); senseReq = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 busy", seekBusy, 0); chk("R1 irq", irq, 0); chk("R1 step", stepOut, 0);
    chk("R1 unload", headUnload, 1); chk("R1 st0", senseSt0, 'h80); chk("R1 nd", nonDmaMode, 0);
    // rate 14 -> 2 ticks, unload 3 -> 48 ticks, load 2 -> 4 ticks, mode 1
    doSpec(8'hE3, 8'h05);
    chk("R11 nonDma", nonDmaMode, 1);
    pulses = 0; doStart(0, 1, 1, 5); waitIrq();
    chk("R2 pulses up", pulses, 5); chk("R3 gap 2 ticks", riseGap, 2 * TDIV);
    chk("R5 st0", senseSt0, 'h25); chk("R2 cyl", senseCyl, 5);
    @(negedge clk); chk("R11 settle", headSettle, 1); chk("R12 unload low", headUnload, 0);
    doSense(); chk("R9 cleared", irq, 0); chk("R9 idle st0", senseSt0, 'h80); chk("R9 idle cyl", senseCyl, 0);
    repeat (300) @(negedge clk); chk("R12 unload high", headUnload, 1);
    pulses = 0; doStart(0, 1, 0, 2); waitIrq();
    chk("R2 pulses down", pulses, 3); chk("R2 cyl down", senseCyl, 2); chk("R5 st0 h0", senseSt0, 'h21);
    doSense();
    pulses = 0; doStart(0, 1, 0, 2); @(negedge clk);
    chk("R6 no pulse", pulses, 0); chk("R6 irq", irq, 1); chk("R6 st0", senseSt0, 'h21);
    doSense();
    pulses = 0; doStart(0, 2, 0, 3); repeat (3) @(negedge clk); doStart(0, 0, 1, 9); waitIrq();
    chk("R10 pulses", pulses, 3); chk("R10 st0", senseSt0, 'h22);
    doSense();
    doStart(0, 0, 0, 0); @(negedge clk);
    chk("R10 other drive idle", senseSt0, 'h20); chk("R10 other cyl", senseCyl, 0);
    doSense();
    pulses = 0; tzAfter = 2; doStart(1, 2, 0, 0); waitIrq();
    chk("R7 pulses", pulses, 2); chk("R7 st0", senseSt0, 'h22); chk("R7 cyl", senseCyl, 0);
    tzAfter = -1; doSense();
    pulses = 0; doStart(0, 3, 0, 3); waitIrq(); doSense();
    pulses = 0; doStart(1, 3, 0, 0); waitIrq();
    chk("R8 pulses", pulses, RLIM); chk("R8 st0", senseSt0, 'h73); chk("R8 cyl", senseCyl, 0);
    doSense();
    tzAfter = 0; repeat (2) @(negedge clk);
    pulses = 0; doStart(1, 1, 0, 0); @(negedge clk);
    chk("R7 immediate pulses", pulses, 0); chk("R7 immediate st0", senseSt0, 'h21);
    chk("R7 immediate cyl", senseCyl, 0);
    tzAfter = -1; doSense();
    doSpec(8'h01, 8'h00);
    pulses = 0; doStart(0, 0, 0, 2); waitIrq();
    chk("R3 gap 16 ticks", riseGap, 16 * TDIV); chk("R2 two pulses", pulses, 2);
    doSense();
    repeat (20) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1; tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule